// File: doc/BRIEF.md
# Serial Management Frame Master

This block is the management-channel master that talks to an external Ethernet PHY over the two-wire management interface. It produces the management clock and drives the bidirectional data line through separate output, output-enable and input pins. A one-cycle request strobe starts a transaction. The request carries a write/read select, a 5-bit PHY address, a 5-bit register index and 16 bits of write data. The block then runs a complete frame and reports the outcome through `busy`, a one-cycle `done`, the captured 16-bit read value and an error flag.

Every frame takes exactly 64 management clock pulses. The first 32 are an all-ones preamble and the next 14 carry the header. The last 18 carry either the write turnaround and data, or the PHY's answer to a read. The management clock half-period is a parameter counted in system clocks. The management clock rests low between frames.

A scan request makes the block look for an attached PHY. It reads the status register at ascending addresses and reports the first address that answers with a nonzero value. If no address answers, it reports a default address.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Each frame opens with 32 management clock pulses during which `mdio_oe`=1 and `mdio_o`=1.
- R2: Pulses 33 to 46 carry the header MSB first: start code 01, then the opcode, then the 5-bit PHY address, then the 5-bit register index. The opcode is 10 for a read and 01 for a write.
- R3: On a write, the master drives the whole frame. Pulses 47 and 48 carry 1 then 0, and pulses 49 to 64 carry the write data MSB first.
- R4: On a read, `mdio_oe` falls only while `mdc` is low and stays low for the last 18 pulses, pulses 47 to 64. Every input bit is sampled on the system clock edge that raises `mdc`.
- R5: If the line reads 1 at pulse 47 of a read, `rd_err`=1 and `rd_data`=0. The remaining 17 pulses are still issued.
- R6: If the line reads 0 at pulse 47, `rd_err`=0 and `rd_data` holds the line values at pulses 49 to 64, MSB first. Pulse 48 is an idle pulse and is not stored.
- R7: Outside a frame, `mdc`=0, `mdio_oe`=1 and `mdio_o`=1.
- R8: Each `mdc` half-period lasts HALF_DIV system clocks. `mdio_o` and `mdio_oe` change only while `mdc` is low. `busy` stays high for exactly 128*HALF_DIV clocks, from the accepting edge to the edge that raises `done`.
- R9: A request that arrives while `busy`=1 is ignored. It changes neither the frame in progress nor any result, and no second frame follows.
- R10: `done` is high for exactly one cycle at the end of each transaction, and `busy`=0 in that cycle.
- R11: A scan reads register 1 at addresses 0, 1, 2 and so on up to 30. It stops at the first address that returns a nonzero value and reports it with `scan_found`=1. The scan then ends with a single `done`.
- R12: If none of addresses 0 to 30 returns a nonzero value, the scan reports `scan_addr`=1 and `scan_found`=0. `rd_data` is then 0.
- R13: While `rst_n`=0, and right after it is released, the outputs are idle: `busy`=0, `done`=0, `rd_data`=0, `rd_err`=0, `scan_addr`=1 and `scan_found`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | One-cycle transaction request |
| req_write | input | 1 | 1 = write frame, 0 = read frame |
| req_scan | input | 1 | 1 = run an address scan instead of a single frame |
| phy_addr | input | 5 | Target PHY address |
| reg_idx | input | 5 | Target register index |
| wr_data | input | 16 | Data for a write frame |
| busy | output | 1 | Transaction or scan in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rd_data | output | 16 | Result of the last read (zero on error) |
| rd_err | output | 1 | Error flag of the last read |
| scan_addr | output | 5 | Address chosen by the last scan |
| scan_found | output | 1 | Last scan found a responding PHY |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The bench plays the part of a PHY. It decodes the header from the line, answers only when both the address and the register match, and otherwise leaves the line pulled high. This means a read with the wrong field order, the wrong opcode or a wrong turnaround position gets no answer and returns an error. A design that sampled one pulse early or late would shift the read value or miss the error bit. The bench uses the values 0xA5C3 and 0x8001 to expose such off-by-one shifts at both ends of the word.

A design that discarded the data pulses after an error would end the frame short and break both the cycle count and the slot alignment. A design that accepted a request while busy would emit a second frame, which the bench sees as `busy` rising again.

The scan is run three times: with a responder at address 5, at the last address 30, and with no responder at all. These runs catch a wrong search order, an early or late stop, and a wrong fallback address. A design that let each internal read's `done` reach the port would produce several `done` pulses during one scan, which the bench counts.

// File: rtl/mdio_pkg.sv
// Package: shared frame layout constants and types for the serial
// management master. Slot numbers count MDC pulses from 0 within a frame.
package mdio_pkg;
    localparam int SLOT_W = 6;
    typedef logic [SLOT_W-1:0] slot_t;

    // frame layout: 32 preamble, 14 header, 18 tail = 64 slots
    localparam slot_t SLOT_HDR  = 6'd32;
    localparam slot_t SLOT_TAIL = 6'd46;
    localparam slot_t SLOT_DATA = 6'd48;
    localparam slot_t SLOT_LAST = 6'd63;

    localparam logic [1:0] CODE_START = 2'b01;
    localparam logic [1:0] CODE_RD    = 2'b10;
    localparam logic [1:0] CODE_WR    = 2'b01;
    localparam logic [1:0] CODE_TA_WR = 2'b10;

    localparam int FRAME_BITS = 32;

    typedef enum logic [1:0] {
        SC_IDLE  = 2'd0,
        SC_ISSUE = 2'd1,
        SC_WAIT  = 2'd2
    } scan_st_t;
endpackage

// File: rtl/mdc_tick_gen.sv
// Module: mdc_tick_gen
// Produces a one-cycle tick every HALF_DIV system clocks while enabled.
// Each tick marks the end of one MDC half-period.
// Assumes: HALF_DIV >= 1. The count restarts from zero whenever en is low.
module mdc_tick_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] CNT_TOP = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == CNT_TOP);

    // count system clocks within one MDC half-period
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    // R8
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && en && $past(en)) |=> !tick || (HALF_DIV == 1));
endmodule

// File: rtl/mdio_frame_engine.sv
// Module: mdio_frame_engine
// Runs one 64-slot management frame (read or write) per accepted start.
// MDC toggles on each tick. Outgoing bits change on the falling tick.
// Incoming bits are sampled on the rising tick.
// Assumes: start is honoured only while idle; tick comes from a divider
// enabled by busy.
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        wr_sel,
    input  logic [4:0]  addr,
    input  logic [4:0]  regi,
    input  logic [15:0] wdata,
    input  logic        tick,
    input  logic        mdio_i,
    output logic        busy,
    output logic        done,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [15:0] rd_data,
    output logic        rd_err
);
    logic                  is_rd;
    slot_t                 slot;
    logic [FRAME_BITS-1:0] sreg;
    logic                  err_q;
    logic [15:0]           rx_sh;
    logic                  rise_now;
    logic                  fall_now;
    logic                  last_fall;

    assign rise_now  = busy && tick && !mdc;
    assign fall_now  = busy && tick && mdc;
    assign last_fall = fall_now && (slot == SLOT_LAST);

    // line drive: preamble ones, then shift register MSB; release read tail
    assign mdio_oe = !(busy && is_rd && (slot >= SLOT_TAIL));
    assign mdio_o  = (busy && (slot >= SLOT_HDR)) ? sreg[FRAME_BITS-1] : 1'b1;

    // frame sequencer: accept, MDC toggling, slot advance, output shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            mdc   <= 1'b0;
            is_rd <= 1'b0;
            slot  <= '0;
            sreg  <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy  <= 1'b1;
                    mdc   <= 1'b0;
                    slot  <= '0;
                    is_rd <= !wr_sel;
                    sreg  <= wr_sel ? {CODE_START, CODE_WR, addr, regi, CODE_TA_WR, wdata}
                                    : {CODE_START, CODE_RD, addr, regi, 18'd0};
                end
            end else if (rise_now) begin
                mdc <= 1'b1;
            end else if (fall_now) begin
                mdc <= 1'b0;
                if (last_fall) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    slot <= slot + slot_t'(1);
                    if (slot >= SLOT_HDR) begin
                        sreg <= {sreg[FRAME_BITS-2:0], 1'b0};
                    end
                end
            end
        end
    end

    // receive path: error bit and 16 data bits sampled at MDC rise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
            rx_sh <= '0;
        end else if (start && !busy) begin
            err_q <= 1'b0;
        end else if (rise_now && is_rd) begin
            if (slot == SLOT_TAIL) begin
                err_q <= mdio_i;
            end else if (slot >= SLOT_DATA) begin
                rx_sh <= {rx_sh[14:0], mdio_i};
            end
        end
    end

    // result registers: updated at the end of a read frame only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            rd_err  <= 1'b0;
        end else if (last_fall && is_rd) begin
            rd_data <= err_q ? 16'd0 : rx_sh;
            rd_err  <= err_q;
        end
    end

    // R8
    out_hold_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R4
    release_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdio_oe) |-> !mdc);

    // R7
    idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mdio_oe && mdio_o && !mdc));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (rd_data == 16'd0));
endmodule

// File: rtl/mdio_scan_ctl.sv
// Module: mdio_scan_ctl
// Walks PHY addresses 0..LAST_ADDR, issuing one status read per address
// through the frame engine. Stops at the first nonzero result; otherwise
// reports FALLBACK_ADDR.
// Assumes: the engine is idle whenever this block asserts start, and a failed
// read returns zero.
module mdio_scan_ctl
    import mdio_pkg::*;
#(
    parameter int LAST_ADDR     = 30,
    parameter int FALLBACK_ADDR = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  logic        eng_done,
    input  logic [15:0] eng_rd_data,
    output logic        active,
    output logic        start,
    output logic [4:0]  cur_addr,
    output logic        scan_done,
    output logic [4:0]  found_addr,
    output logic        found
);
    localparam logic [4:0] ADDR_LAST = 5'(LAST_ADDR);
    localparam logic [4:0] ADDR_FB   = 5'(FALLBACK_ADDR);

    scan_st_t st;

    assign active = (st != SC_IDLE);
    assign start  = (st == SC_ISSUE);

    // scan sequencer: issue a read, judge its result, advance or finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= SC_IDLE;
            cur_addr   <= '0;
            scan_done  <= 1'b0;
            found_addr <= ADDR_FB;
            found      <= 1'b0;
        end else begin
            scan_done <= 1'b0;
            case (st)
                SC_IDLE: begin
                    if (go) begin
                        cur_addr <= '0;
                        st       <= SC_ISSUE;
                    end
                end
                SC_ISSUE: st <= SC_WAIT;
                SC_WAIT: begin
                    if (eng_done) begin
                        if (eng_rd_data != 16'd0) begin
                            found_addr <= cur_addr;
                            found      <= 1'b1;
                            scan_done  <= 1'b1;
                            st         <= SC_IDLE;
                        end else if (cur_addr == ADDR_LAST) begin
                            found_addr <= ADDR_FB;
                            found      <= 1'b0;
                            scan_done  <= 1'b1;
                            st         <= SC_IDLE;
                        end else begin
                            cur_addr <= cur_addr + 5'd1;
                            st       <= SC_ISSUE;
                        end
                    end
                end
                default: st <= SC_IDLE;
            endcase
        end
    end

    // R11
    scan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cur_addr <= ADDR_LAST));

    // R11
    one_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);
endmodule

// File: rtl/mdio_mgmt_master.sv
// Module: mdio_mgmt_master (top)
// Serial management master: accepts single read/write requests or an
// address scan. It shares one frame engine and one MDC divider between
// both uses.
// Assumes: requests are single-cycle strobes; anything arriving while busy
// is dropped.
module mdio_mgmt_master #(
    parameter int HALF_DIV      = 4,
    parameter int SCAN_LAST     = 30,
    parameter int SCAN_FALLBACK = 1,
    parameter int SCAN_REG      = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        req_write,
    input  logic        req_scan,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_idx,
    input  logic [15:0] wr_data,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        rd_err,
    output logic [4:0]  scan_addr,
    output logic        scan_found,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam logic [4:0] STATUS_REG = 5'(SCAN_REG);

    logic        eng_busy, eng_done, eng_start, tick;
    logic        sc_active, sc_start, sc_done;
    logic [4:0]  sc_addr;
    logic        accept;
    logic        eng_wr;
    logic [4:0]  eng_addr, eng_reg;

    assign busy   = eng_busy || sc_active;
    assign accept = req && !busy;

    // route either the external request or the scan's read to the engine
    always_comb begin
        if (sc_active) begin
            eng_start = sc_start;
            eng_wr    = 1'b0;
            eng_addr  = sc_addr;
            eng_reg   = STATUS_REG;
        end else begin
            eng_start = accept && !req_scan;
            eng_wr    = req_write;
            eng_addr  = phy_addr;
            eng_reg   = reg_idx;
        end
    end

    assign done = (eng_done && !sc_active) || sc_done;

    mdc_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (eng_busy),
        .tick (tick)
    );

    mdio_frame_engine u_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (eng_start),
        .wr_sel (eng_wr),
        .addr   (eng_addr),
        .regi   (eng_reg),
        .wdata  (wr_data),
        .tick   (tick),
        .mdio_i (mdio_i),
        .busy   (eng_busy),
        .done   (eng_done),
        .mdc    (mdc),
        .mdio_o (mdio_o),
        .mdio_oe(mdio_oe),
        .rd_data(rd_data),
        .rd_err (rd_err)
    );

    mdio_scan_ctl #(
        .LAST_ADDR    (SCAN_LAST),
        .FALLBACK_ADDR(SCAN_FALLBACK)
    ) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (accept && req_scan),
        .eng_done   (eng_done),
        .eng_rd_data(rd_data),
        .active     (sc_active),
        .start      (sc_start),
        .cur_addr   (sc_addr),
        .scan_done  (sc_done),
        .found_addr (scan_addr),
        .found      (scan_found)
    );

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && $past(eng_busy) && req) |=> $stable(eng_addr) || !sc_active);
endmodule

// File: tb/mdio_mgmt_master_tb_top.sv
module mdio_mgmt_master_tb_top;
    localparam int H   = 4;
    localparam int TXN = 128 * H;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, req, req_write, req_scan;
    logic [4:0]  phy_addr, reg_idx;
    logic [15:0] wr_data;
    logic        busy, done, rd_err, scan_found, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;
    logic [4:0]  scan_addr;
    logic        mdio_i;

    mdio_mgmt_master #(.HALF_DIV(H)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
        .req_scan(req_scan), .phy_addr(phy_addr), .reg_idx(reg_idx),
        .wr_data(wr_data), .busy(busy), .done(done), .rd_data(rd_data),
        .rd_err(rd_err), .scan_addr(scan_addr), .scan_found(scan_found),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int vec_n = 0;
    int miss_n = 0;
    bit finished = 1'b0;

    // PHY responder state
    logic [63:0] cap = '0;
    int          bslot = 0;
    logic [13:0] hdr = '0;
    logic        rsp_en = 1'b0, force_err = 1'b0;
    logic [4:0]  rsp_addr = '0, rsp_reg = 5'd1;
    logic [15:0] rsp_val = '0;
    int          oe_low_n = 0, done_n = 0, bad_half = 0, run = 0;
    logic        prev_mdc = 1'b0;
    logic        phy_hit;

    // record the line at each MDC rise
    always @(posedge mdc) begin
        cap = {cap[62:0], mdio_oe ? mdio_o : mdio_i};
        if (!mdio_oe) oe_low_n++;
    end

    // slot counter (64 per frame) and header latch
    always @(negedge mdc) begin
        bslot = (bslot == 63) ? 0 : bslot + 1;
        if (bslot == 46) hdr = cap[13:0];
    end

    assign phy_hit = rsp_en && (hdr[13:12] == 2'b01) && (hdr[11:10] == 2'b10) &&
                     (hdr[9:5] == rsp_addr) && (hdr[4:0] == rsp_reg);

    always @* begin
        mdio_i = 1'b1;
        if (bslot >= 46 && phy_hit) begin
            if (bslot == 46)      mdio_i = force_err;
            else if (bslot == 47) mdio_i = 1'b0;
            else                  mdio_i = rsp_val[63 - bslot];
        end
    end

    // done counting and MDC half-period measurement
    always @(negedge clk) begin
        if (done) done_n++;
        if (busy) begin
            if (mdc == prev_mdc) run++;
            else begin
                if (run != H) bad_half++;
                run = 1;
            end
        end else run = 0;
        prev_mdc = mdc;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vec_n++;
        if (act !== exp) begin
            miss_n++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_txn(input bit wr, input bit scan, input logic [4:0] a,
                           input logic [4:0] r, input logic [15:0] d,
                           input bit poke, input int limit, output int busy_n);
        @(negedge clk);
        req = 1'b1; req_write = wr; req_scan = scan;
        phy_addr = a; reg_idx = r; wr_data = d;
        @(negedge clk);
        req = 1'b0; req_scan = 1'b0;
        busy_n = 0;
        for (int i = 0; i < limit; i++) begin
            if (done) break;
            if (busy) busy_n++;
            if (poke && i == 100) begin
                req = 1'b1; req_write = 1'b0; phy_addr = ~a; reg_idx = 5'd1;
            end
            if (poke && i == 101) req = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic clear_mon();
        oe_low_n = 0; done_n = 0; bad_half = 0;
    endtask

    task automatic test_write(input logic [4:0] a, input logic [4:0] r, input logic [15:0] d);
        int bn;
        clear_mon();
        run_txn(1'b1, 1'b0, a, r, d, 1'b0, TXN + 50, bn);
        chk("R10 done at end", 64'(done), 64'd1);
        chk("R10 busy low with done", 64'(busy), 64'd0);
        chk("R8 busy length", 64'(bn), 64'(TXN));
        chk("R1 R2 R3 write frame", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, a, r, 2'b10, d});
        chk("R3 master drives all", 64'(oe_low_n), 64'd0);
        @(negedge clk);
        chk("R10 done one cycle", 64'(done), 64'd0);
        chk("R7 idle line", {61'd0, mdc, mdio_oe, mdio_o}, 64'b011);
        @(negedge clk);
        chk("R8 half periods", 64'(bad_half), 64'd0);
        chk("R10 done count", 64'(done_n), 64'd1);
    endtask

    task automatic test_read(input logic [4:0] a, input logic [4:0] r, input logic [15:0] v,
                             input bit present, input bit err);
        int bn;
        rsp_en = present; rsp_addr = a; rsp_reg = r; rsp_val = v; force_err = err;
        clear_mon();
        run_txn(1'b0, 1'b0, a, r, 16'h0, 1'b0, TXN + 50, bn);
        chk("R8 read busy length", 64'(bn), 64'(TXN));
        chk("R2 read header", {18'd0, cap[63:18]}, {18'd0, 32'hFFFF_FFFF, 2'b01, 2'b10, a, r});
        chk("R4 released pulses", 64'(oe_low_n), 64'd18);
        if (!present || err) begin
            chk("R5 error flag", 64'(rd_err), 64'd1);
            chk("R5 data zeroed", 64'(rd_data), 64'd0);
        end else begin
            chk("R6 no error", 64'(rd_err), 64'd0);
            chk("R6 read value", 64'(rd_data), 64'(v));
        end
        @(negedge clk);
        chk("R7 output restored", {62'd0, mdio_oe, mdc}, 64'b10);
        @(negedge clk);
        chk("R8 read half periods", 64'(bad_half), 64'd0);
        rsp_en = 1'b0; force_err = 1'b0;
    endtask

    task automatic test_ignore();
        int bn;
        logic [15:0] prev_rd;
        prev_rd = rd_data;
        clear_mon();
        run_txn(1'b1, 1'b0, 5'h0C, 5'h04, 16'h5A0F, 1'b1, TXN + 50, bn);
        chk("R9 frame untouched", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h0C, 5'h04, 2'b10, 16'h5A0F});
        chk("R9 busy length", 64'(bn), 64'(TXN));
        repeat (20) @(negedge clk);
        chk("R9 no second frame", 64'(busy), 64'd0);
        chk("R9 single done", 64'(done_n), 64'd1);
        chk("R9 read result kept", 64'(rd_data), 64'(prev_rd));
    endtask

    task automatic test_scan(input bit present, input logic [4:0] a, input logic [15:0] v,
                             input logic [4:0] exp_a, input bit exp_f);
        int bn;
        rsp_en = present; rsp_addr = a; rsp_reg = 5'd1; rsp_val = v; force_err = 1'b0;
        clear_mon();
        run_txn(1'b0, 1'b1, 5'h00, 5'h00, 16'h0, 1'b0, 40000, bn);
        chk("R11 scan finished", 64'(done), 64'd1);
        repeat (4) @(negedge clk);
        chk(exp_f ? "R11 scan address" : "R12 fallback address", 64'(scan_addr), 64'(exp_a));
        chk(exp_f ? "R11 scan found" : "R12 not found", 64'(scan_found), 64'(exp_f));
        chk(exp_f ? "R11 status value" : "R12 zero data", 64'(rd_data), 64'(exp_f ? v : 16'd0));
        chk("R11 one done per scan", 64'(done_n), 64'd1);
        rsp_en = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; req = 1'b0; req_write = 1'b0; req_scan = 1'b0;
        phy_addr = '0; reg_idx = '0; wr_data = '0;
        repeat (4) @(negedge clk);
        // R13 reset state
        chk("R13 reset busy/done", {62'd0, busy, done}, 64'd0);
        chk("R13 reset results", {43'd0, rd_data, rd_err, scan_addr, scan_found}, {43'd0, 16'd0, 1'b0, 5'd1, 1'b0});
        chk("R13 reset line", {61'd0, mdc, mdio_oe, mdio_o}, 64'b011);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13 after release", {62'd0, busy, done}, 64'd0);

        test_write(5'h01, 5'h00, 16'h1234);
        test_write(5'h15, 5'h0A, 16'h8001);
        test_read(5'h03, 5'h02, 16'hA5C3, 1'b1, 1'b0);
        test_read(5'h1F, 5'h1F, 16'h8001, 1'b1, 1'b0);
        test_read(5'h07, 5'h01, 16'hFFFF, 1'b1, 1'b1);
        test_read(5'h09, 5'h03, 16'h1111, 1'b0, 1'b0);
        test_ignore();
        test_scan(1'b1, 5'd5, 16'h7949, 5'd5, 1'b1);
        test_scan(1'b1, 5'd30, 16'h0004, 5'd30, 1'b1);
        test_scan(1'b0, 5'd0, 16'h0000, 5'd1, 1'b0);

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vec_n, miss_n);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            vec_n++;
            miss_n++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", vec_n, miss_n);
            $finish;
        end
    end
endmodule